// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block collects up to 32 peripheral interrupt lines and seven dedicated core event lines. It presents a single prioritised request to a processor sequencer. A system stage samples the peripheral lines and gates them with a per-source enable mask. It folds each enabled source onto one of nine general-purpose core levels (7 to 15) through a programmable assignment table. The table resets to a fixed default spread over levels 7 to 13. The system stage also raises a wake indication from a separate enable set, independently of the mask.

The core stage keeps three 16-bit vectors: latched events, level enables and active (pending) handlers. A rising edge on a level input latches that level. The highest-priority unmasked latched level is offered to the sequencer, but only when it beats every handler already running. The sequencer accepts the offer with `ack_i`, which marks the level pending and clears its latch. A return pulse `ret_i` ends the innermost handler. Several pending bits can therefore be set at once, and they record the nesting depth. A global enable, set and cleared by two command pulses, gates all general-purpose levels.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, the latch, pending, status, core mask, system mask and wake-enable vectors are all zero and the global enable is off. Assignment field of source s is s mod 7, so source s routes to level 7 + (s mod 7).
- R2: `src_stat_o[s]` equals `src_irq_i[s]` as sampled at the previous clock edge, whatever the mask holds.
- R3: General-purpose level L (7..15) is driven by the OR of all sources whose system mask bit is 1, whose status bit is 1 and whose 4-bit field equals L-7. A field of 9 or above routes the source nowhere. Source s has its field in the assignment word at address 4 + s/8, bits 4*(s mod 8) + 3 down to 4*(s mod 8).
- R4: `core_evt_i[k]` drives level k (0..6). A rising edge on a level input sets its latch bit at the second clock edge after the source line rises. A line held high latches only once.
- R5: When a level is taken, its latch bit clears at the same edge, unless a new rising edge arrives for that level in that same cycle, in which case the bit stays set.
- R6: Core mask bit 1 enables the level. A latched level whose mask bit is 0 stays latched and is never requested.
- R7: `irq_req_o` is high and `irq_lvl_o` names the lowest-numbered latched, unmasked, gated level, provided that level number is below the lowest set pending bit (or no pending bit is set).
- R8: `ack_i` high while `irq_req_o` is high sets the pending bit of `irq_lvl_o` at the next edge. A source that rises just before edge 1, with `ack_i` held high, is pending after edge 3.
- R9: `ret_i` clears the lowest-numbered set pending bit at the next edge. It has no effect when no pending bit is set.
- R10: The global enable is set by `gie_set_i` and cleared by `gie_clr_i`, with the clear winning when both are high. When it is off, levels 7..15 are never requested but still latch, while levels 0..6 are unaffected.
- R11: `wake_o` is high when any status bit whose wake-enable bit is set is high, regardless of the system mask.
- R12: Configuration writes (`cfg_we_i`) use these addresses: 0 for the core mask (data bits 15:0), 1 for the system mask, 2 for wake enable, and 4..7 for assignment words. Address 3 is ignored. A write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_irq_i | input | 32 | Peripheral interrupt lines, high while asserting |
| core_evt_i | input | 7 | Dedicated event lines for levels 0..6 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| gie_set_i | input | 1 | Global enable set command |
| gie_clr_i | input | 1 | Global enable clear command |
| ack_i | input | 1 | Sequencer accepts the offered level |
| ret_i | input | 1 | Sequencer returns from the innermost handler |
| irq_req_o | output | 1 | A level is offered |
| irq_lvl_o | output | 4 | Offered level number |
| latch_o | output | 16 | Latched event vector |
| pend_o | output | 16 | Pending (active or nested) vector |
| src_stat_o | output | 32 | Registered peripheral status |
| wake_o | output | 1 | Wake indication |

## Verification
A stale or corrupted latch bit shows on `latch_o` one edge later. If it is eligible, it also shows as a wrong `irq_req_o` or `irq_lvl_o` in the same cycle. A pending vector that has lost track of nesting is seen at the first return pulse, when the wrong bit clears and an outer level is re-offered too early. A wrong assignment field or mask bit shows two edges after the source rises, as the latch bit landing on the wrong level or not at all. A broken wake path is visible one edge after the source changes.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int unsigned NUM_LVL     = 16;
  localparam int unsigned LVL_W       = 4;
  localparam int unsigned FIRST_GP    = 7;
  localparam int unsigned NUM_GP      = NUM_LVL - FIRST_GP;
  localparam int unsigned NUM_DEF_LVL = NUM_GP - 2;  // top two levels left for software
  localparam int unsigned FLD_W       = 4;
  localparam int unsigned DW          = 32;
  localparam int unsigned SRC_PER_REG = DW / FLD_W;
  localparam int unsigned CFG_AW      = 3;

  localparam logic [CFG_AW-1:0] ADR_CORE_MASK = 3'd0;
  localparam logic [CFG_AW-1:0] ADR_SYS_MASK  = 3'd1;
  localparam logic [CFG_AW-1:0] ADR_WAKE      = 3'd2;
  localparam int unsigned       ADR_ASG_BASE  = 4;

  typedef struct packed {
    logic              we;
    logic [CFG_AW-1:0] addr;
    logic [DW-1:0]     data;
  } cfg_wr_t;
endpackage

// File: rtl/irq_lsb_find.sv
module irq_lsb_find #(
  parameter int unsigned W  = 16,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_sys_stage.sv
module irq_sys_stage
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_irq_i,
  input  cfg_wr_t            cfg_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_GP-1:0]  gp_lvl_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] stat_q, mask_q, wake_q;
  logic [FLD_W-1:0]   asg_q [NUM_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
      wake_q <= '0;
    end else begin
      stat_q <= src_irq_i;
      if (cfg_i.we && cfg_i.addr == ADR_SYS_MASK) mask_q <= cfg_i.data[NUM_SRC-1:0];
      if (cfg_i.we && cfg_i.addr == ADR_WAKE)     wake_q <= cfg_i.data[NUM_SRC-1:0];
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_asg
    localparam logic [CFG_AW-1:0] ADR = CFG_AW'(ADR_ASG_BASE + s / SRC_PER_REG);
    localparam int unsigned       LSB = FLD_W * (s % SRC_PER_REG);
    localparam logic [FLD_W-1:0]  DEF = FLD_W'(s % NUM_DEF_LVL);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              asg_q[s] <= DEF;
      else if (cfg_i.we && cfg_i.addr == ADR)   asg_q[s] <= cfg_i.data[LSB +: FLD_W];
    end
  end

  logic [NUM_SRC-1:0] live;
  assign live = stat_q & mask_q;

  always_comb begin
    gp_lvl_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int l = 0; l < NUM_GP; l++) begin
        if (live[s] && asg_q[s] == FLD_W'(l)) gp_lvl_o[l] = 1'b1;
      end
    end
  end

  assign stat_o = stat_q;
  assign wake_o = |(stat_q & wake_q);

  AST_STAT_TRACKS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> stat_q == $past(src_irq_i)) else $error("stat"); // R2
  AST_WAKE_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && $past(rst_ni)) |-> $past(|src_irq_i)) else $error("wake"); // R11
endmodule

// File: rtl/irq_core_stage.sv
module irq_core_stage
  import irq_nest_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_GP-1:0]   gp_lvl_i,
  input  logic [FIRST_GP-1:0] core_evt_i,
  input  logic                mask_we_i,
  input  logic [NUM_LVL-1:0]  mask_wdata_i,
  input  logic                gie_set_i,
  input  logic                gie_clr_i,
  input  logic                ack_i,
  input  logic                ret_i,
  output logic                req_o,
  output logic [LVL_W-1:0]    lvl_o,
  output logic [NUM_LVL-1:0]  latch_o,
  output logic [NUM_LVL-1:0]  pend_o
);
  logic [FIRST_GP-1:0] ded_q;
  logic [NUM_LVL-1:0]  prv_q, ilat_q, ipend_q, imask_q;
  logic                gie_q;

  logic [NUM_LVL-1:0] evt_vec, edge_vec, gate, elig, take_vec, ret_vec;
  logic               pick_found, pend_found, take;
  logic [LVL_W-1:0]   pick_idx, pend_idx;

  assign evt_vec  = {gp_lvl_i, ded_q};
  assign edge_vec = evt_vec & ~prv_q;
  assign gate     = {{NUM_GP{gie_q}}, {FIRST_GP{1'b1}}};
  assign elig     = ilat_q & imask_q & gate;

  irq_lsb_find #(.W(NUM_LVL)) u_pick (.vec_i(elig),    .found_o(pick_found), .idx_o(pick_idx));
  irq_lsb_find #(.W(NUM_LVL)) u_pend (.vec_i(ipend_q), .found_o(pend_found), .idx_o(pend_idx));

  assign req_o    = pick_found && (!pend_found || pick_idx < pend_idx);
  assign lvl_o    = pick_idx;
  assign take     = ack_i && req_o;
  assign take_vec = take ? (NUM_LVL'(1) << pick_idx) : '0;
  assign ret_vec  = (ret_i && pend_found) ? (NUM_LVL'(1) << pend_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ded_q   <= '0;
      prv_q   <= '0;
      ilat_q  <= '0;
      ipend_q <= '0;
      imask_q <= '0;
      gie_q   <= 1'b0;
    end else begin
      ded_q   <= core_evt_i;
      prv_q   <= evt_vec;
      ilat_q  <= (ilat_q & ~take_vec) | edge_vec;
      ipend_q <= (ipend_q & ~ret_vec) | take_vec;
      if (mask_we_i) imask_q <= mask_wdata_i;
      if (gie_clr_i)      gie_q <= 1'b0;
      else if (gie_set_i) gie_q <= 1'b1;
    end
  end

  assign latch_o = ilat_q;
  assign pend_o  = ipend_q;

  AST_REQ_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (imask_q[lvl_o] && ilat_q[lvl_o])) else $error("elig"); // R6
  AST_PEND_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ipend_q & ~$past(ipend_q))) |-> $past(ack_i && req_o)) else $error("pend"); // R8
  AST_RET_POPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && |ipend_q && !take) |=> $countones(ipend_q) == $past($countones(ipend_q)) - 1)
    else $error("ret"); // R9
  AST_GIE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && lvl_o >= LVL_W'(FIRST_GP)) |-> gie_q) else $error("gie"); // R10
  AST_TAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !edge_vec[lvl_o]) |=> !ilat_q[$past(lvl_o)]) else $error("take"); // R5
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_irq_i,
  input  logic [FIRST_GP-1:0] core_evt_i,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [DW-1:0]       cfg_wdata_i,
  input  logic                gie_set_i,
  input  logic                gie_clr_i,
  input  logic                ack_i,
  input  logic                ret_i,
  output logic                irq_req_o,
  output logic [LVL_W-1:0]    irq_lvl_o,
  output logic [NUM_LVL-1:0]  latch_o,
  output logic [NUM_LVL-1:0]  pend_o,
  output logic [NUM_SRC-1:0]  src_stat_o,
  output logic                wake_o
);
  cfg_wr_t            cfg;
  logic [NUM_GP-1:0]  gp_lvl;

  assign cfg = '{we: cfg_we_i, addr: cfg_addr_i, data: cfg_wdata_i};

  irq_sys_stage #(.NUM_SRC(NUM_SRC)) u_sys (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_irq_i(src_irq_i),
    .cfg_i    (cfg),
    .stat_o   (src_stat_o),
    .gp_lvl_o (gp_lvl),
    .wake_o   (wake_o)
  );

  irq_core_stage u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gp_lvl_i    (gp_lvl),
    .core_evt_i  (core_evt_i),
    .mask_we_i   (cfg_we_i && cfg_addr_i == ADR_CORE_MASK),
    .mask_wdata_i(cfg_wdata_i[NUM_LVL-1:0]),
    .gie_set_i   (gie_set_i),
    .gie_clr_i   (gie_clr_i),
    .ack_i       (ack_i),
    .ret_i       (ret_i),
    .req_o       (irq_req_o),
    .lvl_o       (irq_lvl_o),
    .latch_o     (latch_o),
    .pend_o      (pend_o)
  );
endmodule

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] src = '0;
  logic [6:0]  evt = '0;
  logic        we = 1'b0, gset = 1'b0, gclr = 1'b0, ack = 1'b0, ret = 1'b0;
  logic [2:0]  adr = '0;
  logic [31:0] wd = '0;
  logic        req, wake;
  logic [3:0]  lvl;
  logic [15:0] lat, pnd;
  logic [31:0] stat;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_nest_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_irq_i(src), .core_evt_i(evt),
    .cfg_we_i(we), .cfg_addr_i(adr), .cfg_wdata_i(wd),
    .gie_set_i(gset), .gie_clr_i(gclr), .ack_i(ack), .ret_i(ret),
    .irq_req_o(req), .irq_lvl_o(lvl), .latch_o(lat), .pend_o(pnd),
    .src_stat_o(stat), .wake_o(wake)
  );

  // reference state
  logic [31:0] m_stat, m_smask, m_wen;
  logic [3:0]  m_asg [32];
  logic [6:0]  m_ded;
  logic [15:0] m_prv, m_ilat, m_ipend, m_imask;
  logic        m_gie;

  function automatic logic [15:0] m_lvl_in();
    logic [15:0] v = {9'b0, m_ded};
    for (int s = 0; s < 32; s++)
      if (m_stat[s] && m_smask[s] && m_asg[s] < 4'd9) v[7 + m_asg[s]] = 1'b1;
    return v;
  endfunction

  function automatic int lowest(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return 16;
  endfunction

  function automatic int m_pick();
    logic [15:0] el = m_ilat & m_imask & {{9{m_gie}}, 7'h7f};
    int b = lowest(el);
    if (b < 16 && b < lowest(m_ipend)) return b;
    return -1;
  endfunction

  task automatic m_reset();
    m_stat = '0; m_smask = '0; m_wen = '0; m_ded = '0; m_prv = '0;
    m_ilat = '0; m_ipend = '0; m_imask = '0; m_gie = 1'b0;
    for (int s = 0; s < 32; s++) m_asg[s] = 4'(s % 7);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    int p = m_pick();
    chk("R2 status", stat, m_stat);
    chk("R4 latch", {16'b0, lat}, {16'b0, m_ilat});
    chk("R8 pending", {16'b0, pnd}, {16'b0, m_ipend});
    chk("R7 request", {31'b0, req}, {31'b0, p >= 0});
    if (p >= 0) chk("R7 level", {28'b0, lvl}, 32'(p));
    chk("R11 wake", {31'b0, wake}, {31'b0, |(m_stat & m_wen)});
  endtask

  task automatic step(input logic [31:0] s, input logic [6:0] e, input logic a, input logic r,
                      input logic en, input logic di, input logic w, input logic [2:0] ad,
                      input logic [31:0] d);
    int          p, lp;
    logic [15:0] lin, tk, rv;
    src = s; evt = e; ack = a; ret = r; gset = en; gclr = di; we = w; adr = ad; wd = d;
    p   = m_pick();
    lin = m_lvl_in();
    tk  = (a && p >= 0) ? (16'd1 << p) : '0;
    lp  = lowest(m_ipend);
    rv  = (r && lp < 16) ? (16'd1 << lp) : '0;
    m_ilat  = (m_ilat & ~tk) | (lin & ~m_prv);
    m_ipend = (m_ipend & ~rv) | tk;
    m_prv   = lin;
    m_stat  = s;
    m_ded   = e;
    if (di) m_gie = 1'b0; else if (en) m_gie = 1'b1;
    if (w) begin
      case (ad)
        3'd0: m_imask = d[15:0];
        3'd1: m_smask = d;
        3'd2: m_wen = d;
        3'd4, 3'd5, 3'd6, 3'd7:
          for (int k = 0; k < 8; k++) m_asg[(ad - 3'd4) * 8 + k] = d[4*k +: 4];
        default: ;
      endcase
    end
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle(input logic [31:0] s, input logic [6:0] e, input logic a, input logic r);
    step(s, e, a, r, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic wr(input logic [2:0] ad, input logic [31:0] d, input logic [31:0] s);
    step(s, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, ad, d);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1c0d));
    m_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 latch", {16'b0, lat}, 0);
    chk("R1 pending", {16'b0, pnd}, 0);
    chk("R1 status/wake/req", {stat[30:0], wake}, 0);
    rst_ni = 1'b1;
    idle(0, 0, 0, 0);
    chk("R1 request", {31'b0, req}, 0);

    wr(3'd0, 32'h0000_ffff, 0);
    wr(3'd1, 32'hffff_ffff, 0);

    // source 0 -> default level 7, global enable still off (R1, R10)
    idle(32'h1, 0, 1, 0);
    chk("R4 no latch after one edge", {16'b0, lat}, 0);
    chk("R2 status bit", {31'b0, stat[0]}, 1);
    idle(32'h1, 0, 1, 0);
    chk("R4 latch at edge two", {16'b0, lat}, 32'h80);
    chk("R10 gated while disabled", {31'b0, req}, 0);
    idle(32'h1, 0, 1, 0);
    step(32'h1, 0, 0, 0, 1'b1, 1'b0, 1'b0, 3'd0, 0);
    chk("R10 offered after enable", {27'b0, req, lvl}, {27'b0, 1'b1, 4'd7});
    idle(32'h1, 0, 1, 0);
    chk("R8 pending set", {16'b0, pnd}, 32'h80);
    chk("R5 latch cleared", {16'b0, lat}, 0);
    idle(0, 0, 0, 1);
    chk("R9 return", {16'b0, pnd}, 0);

    // three-cycle path, source 3 -> level 10 (R8)
    idle(32'h8, 0, 1, 0);
    idle(32'h8, 0, 1, 0);
    idle(32'h8, 0, 1, 0);
    chk("R8 pending after three edges", {16'b0, pnd}, 32'h400);

    // nesting (R7)
    idle(32'hb, 7'h4, 0, 0);
    idle(32'hb, 7'h4, 0, 0);
    chk("R7 highest first", {27'b0, req, lvl}, {27'b0, 1'b1, 4'd2});
    idle(32'hb, 7'h4, 1, 0);
    chk("R7 nested pending", {16'b0, pnd}, 32'h404);
    chk("R7 blocked by level 2", {31'b0, req}, 0);
    idle(32'hb, 7'h4, 0, 1);
    chk("R9 innermost popped", {16'b0, pnd}, 32'h400);
    chk("R7 level 7 beats 10", {27'b0, req, lvl}, {27'b0, 1'b1, 4'd7});
    idle(32'hb, 7'h4, 1, 0);
    chk("R7 level 8 blocked by 7", {31'b0, req}, 0);
    idle(32'hb, 7'h4, 0, 1);
    idle(32'hb, 7'h4, 0, 1);
    chk("R9 outer popped", {16'b0, pnd}, 0);
    idle(32'hb, 7'h4, 1, 0);
    idle(0, 0, 0, 1);
    idle(0, 0, 0, 1);
    chk("R9 empty return", {16'b0, pnd}, 0);

    // core mask (R6)
    wr(3'd0, 32'h0000_feff, 0);
    idle(32'h2, 0, 0, 0);
    idle(32'h2, 0, 0, 0);
    chk("R6 masked stays latched", {15'b0, lat[8], req}, {15'b0, 1'b1, 1'b0});
    wr(3'd0, 32'h0000_ffff, 32'h2);
    chk("R6 unmasked offered", {27'b0, req, lvl}, {27'b0, 1'b1, 4'd8});
    idle(32'h2, 0, 1, 0);
    idle(0, 0, 0, 1);

    // remap source 1 to level 12, then to nowhere (R3, R12)
    wr(3'd4, 32'h0654_3250, 0);
    idle(32'h2, 0, 0, 0);
    idle(32'h2, 0, 0, 0);
    chk("R3 remapped level", {16'b0, lat}, 32'h1000);
    idle(32'h2, 0, 1, 0);
    idle(0, 0, 0, 1);
    wr(3'd4, 32'h0654_3290, 0);
    idle(32'h2, 0, 0, 0);
    idle(32'h2, 0, 0, 0);
    chk("R3 field 9 unrouted", {16'b0, lat}, 0);
    wr(3'd3, 32'hffff_ffff, 0);
    chk("R12 address 3 ignored", {16'b0, lat}, 0);

    // wake regardless of mask (R11)
    wr(3'd1, 32'h0, 0);
    wr(3'd2, 32'h20, 0);
    idle(32'h20, 0, 0, 0);
    chk("R11 wake with mask off", {31'b0, wake}, 1);
    idle(32'h20, 0, 0, 0);
    chk("R3 masked source not routed", {16'b0, lat}, 0);
    idle(0, 0, 0, 0);
    chk("R11 wake drops", {31'b0, wake}, 0);

    // clear wins, dedicated levels still served (R10)
    step(0, 0, 0, 0, 1'b1, 1'b1, 1'b0, 3'd0, 0);
    idle(0, 7'h2, 0, 0);
    idle(0, 7'h2, 0, 0);
    chk("R10 dedicated level ungated", {27'b0, req, lvl}, {27'b0, 1'b1, 4'd1});
    idle(0, 0, 1, 0);
    idle(0, 0, 0, 1);
    wr(3'd1, 32'hffff_ffff, 0);

    // random traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] s = src ^ ($urandom & $urandom & $urandom & $urandom);
      logic [6:0]  e = evt ^ 7'($urandom & $urandom & $urandom);
      logic        w = ($urandom % 40) == 0;
      logic [2:0]  ad = 3'($urandom);
      logic [31:0] d = (ad <= 3'd2) ? ($urandom | $urandom) : $urandom;
      step(s, e, 1'($urandom), ($urandom % 6) == 0, ($urandom % 30) == 0,
           ($urandom % 70) == 0, w, ad, d);
    end
    finish_run();
  end
endmodule